// File: doc/BRIEF.md
# UART FIFO Control with DMA-Ready Flags

This block sits beside a UART's shift registers and holds two 32-byte FIFOs, one for bytes waiting to be sent and one for bytes already received. A single 8-bit control register decides whether the FIFOs are in use. It can flush either FIFO, picks how the two active-low ready flags behave, and sets the fill thresholds at which those flags change. The flags are meant for a DMA engine that moves data in blocks.

Two flag behaviours exist. In single-transfer behaviour the receive flag goes low whenever a byte is waiting, and the transmit flag goes low while the transmit FIFO is empty. In block behaviour each flag has hysteresis. The receive flag goes low at its threshold, or on a time-out pulse, and stays low until the FIFO drains completely. The transmit flag goes low once enough space is free and goes high only when the FIFO is full. Both flags are registered, so they follow the occupancy counts one clock later.

Top module: `uart_fifo_ctl`

## Requirements
- R1: While reset is held, `cfg_rdata` reads 0x00, both counts are 0 and both `txrdy_n` and `rxrdy_n` are 1.
- R2: A control write with bit 0 = 0 stores bit 0 only; bits [7:3] keep their previous values.
- R3: Bits [7:6] pick the receive threshold: 00 gives 8, 01 gives 16, 10 gives 24 and 11 gives 28 bytes. In block behaviour `rxrdy_n` falls when `rx_count` reaches the threshold and not before.
- R4: Bits [5:4] pick the transmit threshold of free entries: 00 gives 16, 01 gives 8, 10 gives 24 and 11 gives 30. In block behaviour `txrdy_n` falls when the free space reaches the threshold.
- R5: A write with bits 0 and 1 set empties the receive FIFO. A write with bits 0 and 2 set empties the transmit FIFO. The other FIFO is untouched, and bits [2:1] always read back as 0.
- R6: Block behaviour applies only when stored bits 0 and 3 are both 1. With bit 3 = 1 and bit 0 = 0, a time-out pulse leaves `rxrdy_n` at 1.
- R7: In block behaviour `txrdy_n` becomes 1 when the transmit FIFO holds 32 bytes. It stays 1 while the free space is below the threshold.
- R8: In block behaviour a `rx_timeout` pulse drives `rxrdy_n` to 0 at the next edge. Once low, `rxrdy_n` stays 0 while any byte remains and returns to 1 after the FIFO becomes empty.
- R9: Outside block behaviour, `rxrdy_n` is 0 exactly when `rx_count` is nonzero, and `txrdy_n` is 0 exactly when `tx_count` is zero.
- R10: A push into a full FIFO and a pop from an empty FIFO change nothing. A push and a pop in the same cycle leave the count unchanged.
- R11: A write with bit 0 = 0 while bit 0 was 1 empties both FIFOs.
- R12: Each FIFO returns bytes in push order, and the head byte is visible on its data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Stored control value (bits [2:1] read 0) |
| tx_push | input | 1 | Write a byte into the transmit FIFO |
| tx_din | input | 8 | Byte to push into the transmit FIFO |
| tx_pop | input | 1 | Remove the transmit head byte |
| tx_dout | output | 8 | Transmit head byte |
| tx_count | output | 6 | Transmit occupancy |
| rx_push | input | 1 | Write a byte into the receive FIFO |
| rx_din | input | 8 | Byte to push into the receive FIFO |
| rx_pop | input | 1 | Remove the receive head byte |
| rx_dout | output | 8 | Receive head byte |
| rx_count | output | 6 | Receive occupancy |
| rx_timeout | input | 1 | Single-cycle receive time-out pulse |
| txrdy_n | output | 1 | Active-low transmit ready flag |
| rxrdy_n | output | 1 | Active-low receive ready flag |

## Verification
The assertions assume the push and pop strobes, the time-out pulse and the write strobe are clean single-clock signals, held stable between edges. They also assume `rx_timeout` is a pulse, not a level, so the receive flag can release once the FIFO is empty. The stimulus changes inputs only on falling edges and drops every strobe after one cycle. It deliberately pushes past full and pops past empty, so the count assertions see those cases as legal input.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

  // Receive threshold in bytes held, indexed by control bits [7:6]
  function automatic int unsigned rx_thresh(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 24;
      default: return 28;
    endcase
  endfunction

  // Transmit threshold in free entries, indexed by control bits [5:4]; the
  // order is deliberately not monotonic
  function automatic int unsigned tx_thresh(input logic [1:0] sel);
    case (sel)
      2'b00:   return 16;
      2'b01:   return 8;
      2'b10:   return 24;
      default: return 30;
    endcase
  endfunction

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       blk_mode;
    logic       en;
  } ctl_t;

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop);

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= din;
  end

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10: occupancy never passes the depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R10: pushing a full FIFO alone does not change it
  a_r10_push_full: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> $stable(count));
  // R10: popping an empty FIFO alone does not change it
  a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> count == '0);

endmodule

// File: rtl/ufc_ctl.sv
module ufc_ctl
  import ufc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output ctl_t       ctl,
  output logic [7:0] rdata,
  output logic       rx_clr,
  output logic       tx_clr
);

  logic gated_wr, disable_wr;

  assign gated_wr   = we && wdata[0];
  assign disable_wr = we && !wdata[0] && ctl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (gated_wr) begin
      ctl.rx_sel   <= wdata[7:6];
      ctl.tx_sel   <= wdata[5:4];
      ctl.blk_mode <= wdata[3];
      ctl.en       <= 1'b1;
    end else if (we) begin
      ctl.en <= 1'b0;
    end
  end

  // flush strobes act on the same edge as the write; nothing of them is stored
  assign rx_clr = (gated_wr && wdata[1]) || disable_wr;
  assign tx_clr = (gated_wr && wdata[2]) || disable_wr;

  assign rdata = {ctl.rx_sel, ctl.tx_sel, ctl.blk_mode, 2'b00, ctl.en};

  // R2: a write without bit 0 keeps the upper fields
  a_r2_gate: assert property (@(posedge clk) disable iff (rst)
    (we && !wdata[0]) |=> (rdata[7:3] == $past(rdata[7:3])) && !rdata[0]);

endmodule

// File: rtl/ufc_ready.sv
module ufc_ready
  import ufc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk,
  input  logic [1:0]    rx_sel,
  input  logic [1:0]    tx_sel,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic          rx_timeout,
  output logic          txrdy_n,
  output logic          rxrdy_n
);

  logic          rx_hold, rx_hold_nx;
  logic [CW-1:0] tx_free;
  logic          rx_hit, tx_hit, tx_full;

  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign rx_hit  = (32'(rx_cnt) >= rx_thresh(rx_sel)) || rx_timeout;
  assign tx_hit  = 32'(tx_free) >= tx_thresh(tx_sel);
  assign tx_full = (tx_cnt == CW'(DEPTH));

  always_comb begin
    if (!blk)            rx_hold_nx = 1'b0;
    else if (rx_hit)     rx_hold_nx = 1'b1;
    else if (rx_cnt == '0) rx_hold_nx = 1'b0;
    else                 rx_hold_nx = rx_hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_hold <= 1'b0;
      rxrdy_n <= 1'b1;
      txrdy_n <= 1'b1;
    end else begin
      rx_hold <= rx_hold_nx;
      rxrdy_n <= blk ? !rx_hold_nx : (rx_cnt == '0);
      if (!blk)         txrdy_n <= (tx_cnt != '0);
      else if (tx_full) txrdy_n <= 1'b1;
      else if (tx_hit)  txrdy_n <= 1'b0;
    end
  end

  // R7: full transmit FIFO in block behaviour raises the flag
  a_r7_full_high: assert property (@(posedge clk) disable iff (rst)
    (blk && tx_cnt == CW'(DEPTH)) |=> txrdy_n);
  // R8: a time-out pulse in block behaviour pulls the receive flag low
  a_r8_timeout_low: assert property (@(posedge clk) disable iff (rst)
    (blk && rx_timeout) |=> !rxrdy_n);
  // R9: single-transfer receive flag follows occupancy
  a_r9_rx_single: assert property (@(posedge clk) disable iff (rst)
    (!blk && rx_cnt != '0) |=> !rxrdy_n);
  // R9: single-transfer transmit flag low only when empty
  a_r9_tx_single: assert property (@(posedge clk) disable iff (rst)
    (!blk && tx_cnt != '0) |=> txrdy_n);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import ufc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          tx_push,
  input  logic [W-1:0]  tx_din,
  input  logic          tx_pop,
  output logic [W-1:0]  tx_dout,
  output logic [CW-1:0] tx_count,
  input  logic          rx_push,
  input  logic [W-1:0]  rx_din,
  input  logic          rx_pop,
  output logic [W-1:0]  rx_dout,
  output logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  output logic          txrdy_n,
  output logic          rxrdy_n
);

  ctl_t ctl;
  logic rx_clr, tx_clr, blk;
  logic tx_full, tx_empty, rx_full, rx_empty;

  ufc_ctl u_ctl (
    .clk, .rst,
    .we(cfg_we), .wdata(cfg_wdata),
    .ctl, .rdata(cfg_rdata),
    .rx_clr, .tx_clr
  );

  ufc_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
    .clk, .rst, .clr(tx_clr),
    .push(tx_push), .din(tx_din), .pop(tx_pop),
    .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  ufc_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
    .clk, .rst, .clr(rx_clr),
    .push(rx_push), .din(rx_din), .pop(rx_pop),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  assign blk = ctl.en && ctl.blk_mode;

  ufc_ready #(.DEPTH(DEPTH)) u_rdy (
    .clk, .rst, .blk,
    .rx_sel(ctl.rx_sel), .tx_sel(ctl.tx_sel),
    .rx_cnt(rx_count), .tx_cnt(tx_count),
    .rx_timeout, .txrdy_n, .rxrdy_n
  );

  // R5: receive flush write empties the receive FIFO
  a_r5_rx_flush: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[0] && cfg_wdata[1]) |=> rx_count == '0);
  // R5: transmit flush write empties the transmit FIFO
  a_r5_tx_flush: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[0] && cfg_wdata[2]) |=> tx_count == '0);
  // R11: turning the FIFOs off empties both
  a_r11_off_flush: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_wdata[0] && cfg_rdata[0]) |=> (rx_count == '0) && (tx_count == '0));

endmodule

// File: tb/sim_uart_fifo_ctl.sv
module sim_uart_fifo_ctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout;
  logic [5:0] tx_count, rx_count;
  logic       rx_timeout = 1'b0;
  logic       txrdy_n, rxrdy_n;
  int total = 0;
  int bad = 0;

  always #2.5 clk = !clk;

  uart_fifo_ctl u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = b;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_push = 1'b1; tx_din = b;
    @(negedge clk); tx_push = 1'b0;
  endtask
  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_din = b;
    @(negedge clk); rx_push = 1'b0;
  endtask
  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask
  task automatic pop_rx();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask
  task automatic settle();
    @(negedge clk);
  endtask
  task automatic pulse_to();
    @(negedge clk); rx_timeout = 1'b1;
    @(negedge clk); rx_timeout = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    chk("R1 rdata", cfg_rdata, 8'h00);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 txrdy_n", txrdy_n, 1);
    chk("R1 rxrdy_n", rxrdy_n, 1);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_gate_r2_r6();
    wr(8'hC9);
    chk("R2 full write", cfg_rdata, 8'hC9);
    wr(8'h36);
    chk("R2 gated write", cfg_rdata, 8'hC8);
    settle();
    pulse_to();
    chk("R6 no block when disabled", rxrdy_n, 1);
  endtask

  task automatic t_order_r12();
    wr(8'h07);
    push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
    push_rx(8'h5E); push_rx(8'h6F);
    chk("R12 tx head0", tx_dout, 8'hA1); pop_tx();
    chk("R12 tx head1", tx_dout, 8'hB2); pop_tx();
    chk("R12 tx head2", tx_dout, 8'hC3); pop_tx();
    chk("R12 rx head0", rx_dout, 8'h5E); pop_rx();
    chk("R12 rx head1", rx_dout, 8'h6F); pop_rx();
    chk("R12 tx emptied", tx_count, 0);
  endtask

  task automatic t_bounds_r10();
    wr(8'h07);
    for (int i = 0; i < 34; i++) push_tx(8'(i));
    chk("R10 push into full", tx_count, 32);
    for (int i = 0; i < 33; i++) pop_tx();
    chk("R10 pop from empty", tx_count, 0);
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    @(negedge clk); tx_push = 1'b1; tx_pop = 1'b1;
    @(negedge clk); tx_push = 1'b0; tx_pop = 1'b0;
    chk("R10 push+pop same cycle", tx_count, 5);
  endtask

  task automatic t_flush_r5_r11();
    wr(8'h07);
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    push_rx(8'h44); push_rx(8'h55);
    wr(8'h03);
    chk("R5 rx flushed", rx_count, 0);
    chk("R5 tx untouched", tx_count, 3);
    chk("R5 bits read 0", cfg_rdata, 8'h01);
    wr(8'h05);
    chk("R5 tx flushed", tx_count, 0);
    push_tx(8'h66); push_rx(8'h77);
    wr(8'h00);
    chk("R11 tx emptied", tx_count, 0);
    chk("R11 rx emptied", rx_count, 0);
  endtask

  task automatic t_single_r9();
    wr(8'h07);
    settle();
    chk("R9 rx empty", rxrdy_n, 1);
    chk("R9 tx empty", txrdy_n, 0);
    push_rx(8'h01); push_tx(8'h02);
    settle();
    chk("R9 rx holds byte", rxrdy_n, 0);
    chk("R9 tx holds byte", txrdy_n, 1);
    wr(8'h00);
    push_rx(8'h03);
    settle();
    chk("R9 disabled rx holds byte", rxrdy_n, 0);
  endtask

  task automatic t_rx_trig_r3();
    int th[4] = '{8, 16, 24, 28};
    for (int s = 0; s < 4; s++) begin
      wr({2'(s), 6'b001011});
      settle();
      for (int i = 0; i < th[s] - 1; i++) push_rx(8'(i));
      settle();
      chk($sformatf("R3 sel%0d below", s), rxrdy_n, 1);
      push_rx(8'hFF);
      settle();
      chk($sformatf("R3 sel%0d at level", s), rxrdy_n, 0);
      for (int i = 0; i < th[s] - 1; i++) pop_rx();
      settle();
      chk($sformatf("R8 sel%0d holds", s), rxrdy_n, 0);
      pop_rx();
      settle();
      chk($sformatf("R8 sel%0d release", s), rxrdy_n, 1);
    end
  endtask

  task automatic t_tx_trig_r4_r7();
    int th[4] = '{16, 8, 24, 30};
    for (int s = 0; s < 4; s++) begin
      wr({2'b00, 2'(s), 4'b1101});
      settle();
      chk($sformatf("R4 sel%0d empty", s), txrdy_n, 0);
      for (int i = 0; i < 32; i++) push_tx(8'(i));
      settle();
      chk($sformatf("R7 sel%0d full", s), txrdy_n, 1);
      for (int i = 0; i < th[s] - 1; i++) pop_tx();
      settle();
      chk($sformatf("R7 sel%0d below level", s), txrdy_n, 1);
      pop_tx();
      settle();
      chk($sformatf("R4 sel%0d at level", s), txrdy_n, 0);
    end
  endtask

  task automatic t_timeout_r8();
    wr(8'hCB);
    push_rx(8'h10); push_rx(8'h20);
    settle();
    chk("R8 below level", rxrdy_n, 1);
    pulse_to();
    chk("R8 timeout low", rxrdy_n, 0);
    pop_rx(); settle();
    chk("R8 held with data", rxrdy_n, 0);
    pop_rx(); settle();
    chk("R8 released empty", rxrdy_n, 1);
    pulse_to();
    chk("R8 empty timeout low", rxrdy_n, 0);
    settle();
    chk("R8 empty timeout release", rxrdy_n, 1);
  endtask

  initial begin
    t_reset();
    t_gate_r2_r6();
    t_order_r12();
    t_bounds_r10();
    t_flush_r5_r11();
    t_single_r9();
    t_rx_trig_r3();
    t_tx_trig_r4_r7();
    t_timeout_r8();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule